// File: doc/BRIEF.md
# PRBS Synchronization Monitor with Error Counter

This block checks a received serial test sequence against a locally regenerated pseudo-random sequence. The sequence is either the 2^15-1 or the 2^20-1 maximal-length pattern, and the received data may arrive inverted. The block takes one bit per clock whenever a bit-valid strobe is high. Each bit is compared with the value that the sequence recurrence predicts from a history register. The errors are totalled over back-to-back, non-overlapping windows of 64 bits. At the end of each window a lock flag is set or cleared by comparing that total against a threshold of six.

While unlocked, the checker fills its history with the received bits, so it acquires the sequence from the line by itself. While locked, it runs the history from its own predictions, so a single corrupted bit produces exactly one error. Changes of the lock flag are captured in a sticky event flag. That flag can either catch only lock acquisition or catch every change, and a mask turns it into an interrupt request. A saturating 16-bit counter totals bit errors. A read strobe snapshots the counter into a holding register and restarts the count.

Top module: `prbs_sync_mon`

## Requirements
- R1: After a synchronous reset, sync_o, flag_o and irq_o are 0, err_cnt_o is 0, the history is all zero, and window counting starts at the first valid bit.
- R2: Each valid bit d = rx_bit XOR rx_invert is compared with a predicted bit p. While sync_o is 0 the history shifts in d. While sync_o is 1 it shifts in p, so each corrupted line bit yields exactly one error.
- R3: Valid bits are grouped into consecutive, non-overlapping windows of 64, counted from reset. When a window's last bit is clocked in, sync_o becomes 1 if the window held 6 or fewer errors and 0 if it held 7 or more. sync_o changes at no other time.
- R4: With rx_invert=1, a bit-inverted sequence is accepted as error-free. An inverted sequence received with rx_invert=0 makes every bit an error.
- R5: With edge_any=0 only a 0-to-1 change of sync_o sets flag_o. With edge_any=1 any change of sync_o sets flag_o. The flag is set in the same cycle that sync_o changes.
- R6: flag_o stays set until a cycle with flag_clr=1 clears it. If a qualifying sync change occurs in that same cycle, flag_o stays 1.
- R7: irq_o equals flag_o AND the value irq_mask had one clock earlier.
- R8: A bit error increments the running error count only when cnt_src is 2'b00. With any other cnt_src value the count holds.
- R9: The running error count saturates at 16'hFFFF.
- R10: On a cycle with cnt_rd=1, err_cnt_o takes the running count from before that cycle. The running count restarts at 0, or at 1 if a counted error occurs in that same cycle. err_cnt_o changes only on cnt_rd.
- R11: With mode_long=0, p = h[14] XOR h[13]. With mode_long=1, p = h[19] XOR h[16]. Here h[k] is the history bit shifted in k+1 valid bits earlier. These are the recurrences x^15+x^14+1 and x^20+x^17+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Received bit valid this cycle |
| rx_bit | input | 1 | Received data bit |
| mode_long | input | 1 | 0: 2^15-1 sequence, 1: 2^20-1 sequence |
| rx_invert | input | 1 | Expect inverted sequence polarity |
| edge_any | input | 1 | 0: flag on lock gain only, 1: flag on any lock change |
| irq_mask | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the sticky flag |
| cnt_src | input | 2 | Error counter source select; counts bit errors at 2'b00 |
| cnt_rd | input | 1 | Snapshot-and-restart strobe for the error counter |
| sync_o | output | 1 | Lock status |
| flag_o | output | 1 | Sticky lock-change flag |
| irq_o | output | 1 | Interrupt request |
| err_cnt_o | output | 16 | Error count held at the last read |

## Verification
The bound checker enforces the following rules on every cycle:
- sync_o moves only after a valid bit.
- Every acquisition of lock, and every loss of lock in any-edge mode, leaves flag_o set.
- A clear with no coincident change empties the flag.
- irq_o follows the flag and the delayed mask.
- The running count holds when its source is deselected, never wraps past full scale, and restarts on a read.
- err_cnt_o moves only on a read.

The following properties can be shown only by the bench's window sequences:
- The exact six/seven error threshold.
- One error counted per corrupted bit after lock.
- Self-acquisition after loss of lock.
- Polarity handling.
- The long-sequence recurrence.
- Saturation after tens of thousands of errors.
- The clear-versus-event priority.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  typedef enum logic {
    SEQ_SHORT = 1'b0,
    SEQ_LONG  = 1'b1
  } seq_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
  import prbs_mon_pkg::*;
#(
  parameter int SHORT_A = 15,
  parameter int SHORT_B = 14,
  parameter int LONG_A  = 20,
  parameter int LONG_B  = 17,
  localparam int HIST_W = max_int(max_int(SHORT_A, SHORT_B), max_int(LONG_A, LONG_B))
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  input  logic invert,
  input  logic long_sel,
  input  logic locked,
  output logic mis
);
  logic [HIST_W-1:0] hist_q;
  logic              data_n;
  logic              pred;
  seq_mode_e         mode;

  assign mode   = seq_mode_e'(long_sel);
  assign data_n = bit_in ^ invert;

  always_comb begin
    if (mode == SEQ_LONG) pred = hist_q[LONG_A-1] ^ hist_q[LONG_B-1];
    else                  pred = hist_q[SHORT_A-1] ^ hist_q[SHORT_B-1];
  end

  assign mis = bit_en & (pred ^ data_n);

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else if (bit_en) hist_q <= {hist_q[HIST_W-2:0], (locked ? pred : data_n)};
  end
endmodule

// File: rtl/prbs_win_judge.sv
module prbs_win_judge #(
  parameter int WIN_LEN = 64,
  parameter int ERR_MAX = 6,
  localparam int POS_W  = $clog2(WIN_LEN),
  localparam int ERR_W  = $clog2(WIN_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic mis,
  output logic sync_q,
  output logic gain,
  output logic loss
);
  logic [POS_W-1:0] pos_q;
  logic [ERR_W-1:0] errs_q;
  logic [ERR_W-1:0] total;
  logic             last;
  logic             good;

  assign last  = bit_en && (pos_q == POS_W'(WIN_LEN - 1));
  assign total = errs_q + {{(ERR_W-1){1'b0}}, mis};
  assign good  = (total <= ERR_W'(ERR_MAX));
  assign gain  = last & good & ~sync_q;
  assign loss  = last & ~good & sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      errs_q <= '0;
      sync_q <= 1'b0;
    end else if (bit_en) begin
      if (last) begin
        pos_q  <= '0;
        errs_q <= '0;
        sync_q <= good;
      end else begin
        pos_q  <= pos_q + 1'b1;
        errs_q <= total;
      end
    end
  end
endmodule

// File: rtl/prbs_evt_flag.sv
module prbs_evt_flag (
  input  logic clk,
  input  logic rst,
  input  logic gain,
  input  logic loss,
  input  logic edge_any,
  input  logic flag_clr,
  input  logic irq_mask,
  output logic flag_q,
  output logic irq_q
);
  logic hit;
  logic flag_n;

  assign hit    = gain | (edge_any & loss);
  assign flag_n = hit | (flag_q & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      irq_q  <= flag_n & irq_mask;
    end
  end
endmodule

// File: rtl/prbs_err_ctr.sv
module prbs_err_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mis,
  input  logic             count_en,
  input  logic             rd,
  output logic [CNT_W-1:0] run_q,
  output logic [CNT_W-1:0] hold_q
);
  logic inc;
  logic full;

  assign inc  = count_en & mis;
  assign full = &run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      hold_q <= '0;
    end else if (rd) begin
      hold_q <= run_q;
      run_q  <= {{(CNT_W-1){1'b0}}, inc};
    end else if (inc && !full) begin
      run_q  <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon #(
  parameter int WIN_LEN = 64,
  parameter int ERR_MAX = 6,
  parameter int CNT_W   = 16,
  parameter int SRC_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_en,
  input  logic             rx_bit,
  input  logic             mode_long,
  input  logic             rx_invert,
  input  logic             edge_any,
  input  logic             irq_mask,
  input  logic             flag_clr,
  input  logic [SRC_W-1:0] cnt_src,
  input  logic             cnt_rd,
  output logic             sync_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic             mis;
  logic             sync_q;
  logic             gain;
  logic             loss;
  logic [CNT_W-1:0] run_cnt;

  prbs_ref_gen u_ref (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (rx_en),
    .bit_in   (rx_bit),
    .invert   (rx_invert),
    .long_sel (mode_long),
    .locked   (sync_q),
    .mis      (mis)
  );

  prbs_win_judge #(.WIN_LEN(WIN_LEN), .ERR_MAX(ERR_MAX)) u_win (
    .clk    (clk),
    .rst    (rst),
    .bit_en (rx_en),
    .mis    (mis),
    .sync_q (sync_q),
    .gain   (gain),
    .loss   (loss)
  );

  prbs_evt_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .gain     (gain),
    .loss     (loss),
    .edge_any (edge_any),
    .flag_clr (flag_clr),
    .irq_mask (irq_mask),
    .flag_q   (flag_o),
    .irq_q    (irq_o)
  );

  prbs_err_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .mis      (mis),
    .count_en (cnt_src == '0),
    .rd       (cnt_rd),
    .run_q    (run_cnt),
    .hold_q   (err_cnt_o)
  );

  assign sync_o = sync_q;
endmodule

// File: rtl/prbs_sync_mon_chk.sv
module prbs_sync_mon_chk #(
  parameter int CNT_W = 16,
  parameter int SRC_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_en,
  input logic             edge_any,
  input logic             irq_mask,
  input logic             flag_clr,
  input logic [SRC_W-1:0] cnt_src,
  input logic             cnt_rd,
  input logic             sync_o,
  input logic             flag_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic [CNT_W-1:0] run_cnt
);
  p_sync_only_on_bit_r3: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> $stable(sync_o));

  p_gain_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> flag_o);

  p_loss_any_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(sync_o) && $past(edge_any)) |-> flag_o);

  p_clear_empties_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_clr) && $stable(sync_o)) |-> !flag_o);

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == (flag_o && $past(irq_mask))));

  p_src_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_src != '0 && !cnt_rd) |=> $stable(run_cnt));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (!cnt_rd) |=> (run_cnt >= $past(run_cnt)));

  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_rd |=> (run_cnt <= CNT_W'(1)));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !cnt_rd |=> $stable(err_cnt_o));
endmodule

bind prbs_sync_mon prbs_sync_mon_chk #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .edge_any  (edge_any),
  .irq_mask  (irq_mask),
  .flag_clr  (flag_clr),
  .cnt_src   (cnt_src),
  .cnt_rd    (cnt_rd),
  .sync_o    (sync_o),
  .flag_o    (flag_o),
  .irq_o     (irq_o),
  .err_cnt_o (err_cnt_o),
  .run_cnt   (run_cnt)
);

// File: tb/prbs_sync_mon_tb_top.sv
module prbs_sync_mon_tb_top;
  localparam int CLK_PER = 10;
  localparam int WIN     = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_en = 1'b0, rx_bit = 1'b0, mode_long = 1'b0, rx_invert = 1'b0;
  logic        edge_any = 1'b0, irq_mask = 1'b0, flag_clr = 1'b0, cnt_rd = 1'b0;
  logic [1:0]  cnt_src = 2'b00;
  logic        sync_o, flag_o, irq_o;
  logic [15:0] err_cnt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [19:0] g_s;

  always #(CLK_PER/2) clk = ~clk;

  prbs_sync_mon dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit), .mode_long(mode_long),
    .rx_invert(rx_invert), .edge_any(edge_any), .irq_mask(irq_mask),
    .flag_clr(flag_clr), .cnt_src(cnt_src), .cnt_rd(cnt_rd),
    .sync_o(sync_o), .flag_o(flag_o), .irq_o(irq_o), .err_cnt_o(err_cnt_o)
  );

  function automatic logic gen_next();
    logic nb;
    nb  = mode_long ? (g_s[19] ^ g_s[16]) : (g_s[14] ^ g_s[13]);
    g_s = {g_s[18:0], nb};
    return nb;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_en = 1'b0; flag_clr = 1'b0; cnt_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    g_s = 20'h00001;
  endtask

  // 64 bits; the first nerr are corrupted, inv flips the whole line
  task automatic send_window(input int nerr, input bit inv, input bit clr_last);
    for (int i = 0; i < WIN; i++) begin
      logic b;
      b = gen_next();
      if (i < nerr) b = ~b;
      if (inv) b = ~b;
      @(negedge clk);
      rx_en = 1'b1; rx_bit = b; flag_clr = clr_last && (i == WIN-1);
    end
    @(negedge clk);
    rx_en = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); cnt_rd = 1'b1;
    @(negedge clk); cnt_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    g_s = 20'h00001;
    do_reset();
    check("R1 sync after reset", sync_o, 0);
    check("R1 flag after reset", flag_o, 0);
    check("R1 irq after reset", irq_o, 0);
    check("R1 count after reset", err_cnt_o, 0);

    irq_mask = 1'b1;
    send_window(0, 0, 0);
    send_window(0, 0, 0);
    check("R3 lock on clean 2^15-1", sync_o, 1);
    check("R5 gain sets flag", flag_o, 1);
    check("R7 irq with mask", irq_o, 1);

    pulse_clr();
    check("R6 clear strobe", flag_o, 0);
    check("R7 irq follows clear", irq_o, 0);

    do_read();
    send_window(6, 0, 0);
    check("R3 six errors keeps lock", sync_o, 1);
    do_read();
    check("R2 one count per flipped bit (6)", err_cnt_o, 6);

    send_window(7, 0, 0);
    check("R3 seven errors drops lock", sync_o, 0);
    check("R5 loss ignored with edge_any=0", flag_o, 0);
    do_read();
    check("R8 count of seven", err_cnt_o, 7);

    send_window(0, 0, 0);
    check("R2 reacquire from line", sync_o, 1);
    check("R5 regain sets flag", flag_o, 1);
    do_read();
    check("R2 no errors while reacquiring", err_cnt_o, 0);

    edge_any = 1'b1; irq_mask = 1'b0;
    pulse_clr();
    send_window(7, 0, 0);
    check("R3 drop again", sync_o, 0);
    check("R5 loss flagged with edge_any=1", flag_o, 1);
    check("R7 irq masked", irq_o, 0);
    @(negedge clk); irq_mask = 1'b1;
    @(negedge clk);
    check("R7 irq after mask set", irq_o, 1);

    pulse_clr();
    check("R6 cleared before priority test", flag_o, 0);
    send_window(0, 0, 1);
    check("R6 event beats clear: sync", sync_o, 1);
    check("R6 event beats clear: flag", flag_o, 1);

    send_window(0, 1, 0);
    check("R4 wrong polarity drops lock", sync_o, 0);
    rx_invert = 1'b1;
    send_window(0, 1, 0);
    check("R4 inverted line accepted", sync_o, 1);
    do_read();
    send_window(0, 1, 0);
    do_read();
    check("R4 inverted line error-free", err_cnt_o, 0);

    cnt_src = 2'b01;
    do_read();
    send_window(3, 1, 0);
    check("R8 lock kept with 3 errors", sync_o, 1);
    do_read();
    check("R8 no count with src=01", err_cnt_o, 0);
    cnt_src = 2'b00;

    send_window(2, 1, 0);
    begin
      logic b;
      b = ~gen_next();
      @(negedge clk);
      rx_en = 1'b1; rx_bit = ~b; cnt_rd = 1'b1;
      @(negedge clk);
      rx_en = 1'b0; cnt_rd = 1'b0;
    end
    check("R10 snapshot excludes same-cycle error", err_cnt_o, 2);
    do_read();
    check("R10 same-cycle error in new interval", err_cnt_o, 1);

    do_reset();
    rx_invert = 1'b0; mode_long = 1'b1;
    g_s = 20'h00001;
    send_window(0, 0, 0);
    send_window(0, 0, 0);
    check("R11 lock on 2^20-1", sync_o, 1);
    do_read();
    send_window(5, 0, 0);
    check("R11 five errors keep lock", sync_o, 1);
    do_read();
    check("R11 one count per flipped bit (5)", err_cnt_o, 5);

    for (int w = 0; w < 1032; w++) send_window(0, 1, 0);
    check("R4 polarity mismatch loses lock", sync_o, 0);
    do_read();
    check("R9 saturated count", err_cnt_o, 16'hFFFF);
    do_read();
    check("R10 restart after read", err_cnt_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule